// File: doc/BRIEF.md
# Block-Mode Channel Transfer Engine

This engine moves a block of 32-bit words for one channel between a word-organised RAM and a device. The caller presents the channel's control word, start address and block word together with a one-cycle start strobe. The engine decodes the transfer direction, the address step and the counting mode. It works out how many words to move, then moves at most one word per clock until the count is used up.

When reading from RAM, each word goes straight out on a valid/ready output stream. When writing to RAM, the words come either from a valid/ready input stream or from a built-in generator. The generator lays down a chain in which each entry holds the address of its neighbour one word lower, and the final entry holds a terminator. When the last word has moved, the engine raises a one-cycle done pulse and hands back the control word with its enable and trigger bits cleared.

Top module: `blk_dma_engine`

## Requirements
- R1: A start strobe is accepted only while the engine is idle, control bit 24 (enable) is 1 and the counting mode is 0 or 1. Any other strobe is ignored: `busy_o` stays 0, no done pulse appears and `ctl_o` keeps its value.
- R2: Control word decode: bit 0 = 1 moves words from RAM to the output stream and bit 0 = 0 moves words into RAM. Bit 1 = 0 steps the address up and bit 1 = 1 steps it down. Bits 10:9 give the counting mode.
- R3: In counting mode 0 the number of words is the block word's bits 15:0, and a value of 0 there means 65536 words.
- R4: In counting mode 1 the number of words is bits 15:0 times bits 31:16 of the block word. A product of zero moves no word and gives a done pulse on the cycle after the strobe.
- R5: The first access uses the start address. Each moved word shifts the address by 4 in the chosen direction, and `ram_addr_o` is always the current address ANDed with 0x1FFFFC.
- R6: When reading from RAM, each word read appears on `out_data_o` with `out_valid_o` in the same cycle. A RAM read is only requested while `out_ready_i` is 1, so every word is delivered exactly once and in address order.
- R7: When writing to RAM with `otc_mode_i` = 1 at the strobe, every word written is (current address − 4) ANDed with 0x1FFFFF, except the final word, which is 0xFFFFFF.
- R8: When writing to RAM with `otc_mode_i` = 0, each word taken from the input stream (`in_valid_i` and `in_ready_o` both 1) is written at the current address, in order.
- R9: A word moves only in a cycle where `ram_req_o` and `ram_ready_i` are both 1. In any other busy cycle the address and the remaining count hold.
- R10: On the cycle after the last word moves, `done_o` is 1 for exactly one cycle and `busy_o` is 0. `ctl_o` then equals the accepted control word with bits 24 (enable) and 28 (trigger) cleared.
- R11: After reset `busy_o`, `done_o` and `ctl_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe |
| ctl_i | input | 32 | Channel control word |
| base_i | input | 32 | Start byte address |
| blk_i | input | 32 | Block word: size in 15:0, count in 31:16 |
| otc_mode_i | input | 1 | Use the chain generator for RAM writes |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ctl_o | output | 32 | Held control word, enable and trigger cleared at the end |
| ram_req_o | output | 1 | RAM access request |
| ram_we_o | output | 1 | RAM write (1) or read (0) |
| ram_addr_o | output | 21 | RAM byte address, word aligned |
| ram_wdata_o | output | 32 | RAM write data |
| ram_rdata_i | input | 32 | RAM read data, valid while ready |
| ram_ready_i | input | 1 | RAM accepts or returns a word this cycle |
| out_valid_o | output | 1 | Output stream word valid |
| out_data_o | output | 32 | Output stream word |
| out_ready_i | input | 1 | Output stream sink ready |
| in_valid_i | input | 1 | Input stream word valid |
| in_data_i | input | 32 | Input stream word |
| in_ready_o | output | 1 | Input stream word taken |

## Verification
Some properties are checked by assertions on every cycle. These are: the shape of the done pulse and the cleared control bits that go with it, address hold during stalls, the ±4 step between consecutive accesses, and silence on the RAM and stream ports while idle. Other behaviour can only be shown by the bench's scenarios, because it depends on totals and on data values. This covers the word count for each counting mode, including the zero and 65536 cases. It also covers the exact chain contents and terminator, delivery of streamed data in order under ready stalls, and the rejection of strobes that must be ignored.

// File: rtl/blk_dma_pkg.sv
package blk_dma_pkg;

    typedef enum logic [1:0] {
        SYNC_WHOLE  = 2'd0,
        SYNC_BLOCKS = 2'd1,
        SYNC_LIST   = 2'd2,
        SYNC_RSVD   = 2'd3
    } sync_e;

    typedef struct packed {
        logic  from_ram;
        logic  step_down;
        sync_e sync;
    } xfer_cfg_t;

    localparam int CTL_W       = 32;
    localparam int EN_BIT      = 24;
    localparam int TRIG_BIT    = 28;
    localparam int DIR_BIT     = 0;
    localparam int STEP_BIT    = 1;
    localparam int SYNC_LSB    = 9;

endpackage

// File: rtl/blk_dma_decode.sv
module blk_dma_decode
    import blk_dma_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [CTL_W-1:0] ctl_i,
    input  logic [31:0]      blk_i,
    output xfer_cfg_t        cfg_o,
    output logic             legal_o,
    output logic [CNT_W-1:0] count_o
);

    localparam int SIZE_W = 16;
    localparam logic [CNT_W-1:0] FULL_BLOCK = CNT_W'(1) << SIZE_W;

    logic [SIZE_W-1:0] size_w;
    logic [SIZE_W-1:0] reps_w;

    assign size_w = blk_i[SIZE_W-1:0];
    assign reps_w = blk_i[31:SIZE_W];

    always_comb begin
        cfg_o.from_ram  = ctl_i[DIR_BIT];
        cfg_o.step_down = ctl_i[STEP_BIT];
        cfg_o.sync      = sync_e'(ctl_i[SYNC_LSB+1:SYNC_LSB]);
        legal_o         = 1'b0;
        count_o         = '0;
        case (cfg_o.sync)
            SYNC_WHOLE: begin
                legal_o = 1'b1;
                count_o = (size_w == '0) ? FULL_BLOCK : CNT_W'(size_w);
            end
            SYNC_BLOCKS: begin
                legal_o = 1'b1;
                count_o = CNT_W'(32'(size_w) * 32'(reps_w));
            end
            default: begin
                legal_o = 1'b0;
                count_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/blk_dma_addr_step.sv
module blk_dma_addr_step #(
    parameter int AW     = 32,
    parameter int RAM_AW = 21,
    parameter int DATA_W = 32
) (
    input  logic [AW-1:0]     addr_i,
    input  logic              down_i,
    output logic [AW-1:0]     next_o,
    output logic [RAM_AW-1:0] ram_addr_o
);

    localparam int WORD_BYTES = DATA_W / 8;
    localparam int LSB_W      = $clog2(WORD_BYTES);

    always_comb begin
        if (down_i) next_o = addr_i - AW'(WORD_BYTES);
        else        next_o = addr_i + AW'(WORD_BYTES);
        ram_addr_o = {addr_i[RAM_AW-1:LSB_W], {LSB_W{1'b0}}};
    end

endmodule

// File: rtl/blk_dma_otc_gen.sv
module blk_dma_otc_gen #(
    parameter int AW     = 32,
    parameter int RAM_AW = 21,
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] TERM = 32'h00FF_FFFF
) (
    input  logic [AW-1:0]     addr_i,
    input  logic              last_i,
    output logic [DATA_W-1:0] word_o
);

    localparam int WORD_BYTES = DATA_W / 8;

    logic [AW-1:0] prev_w;

    always_comb begin
        prev_w = addr_i - AW'(WORD_BYTES);
        if (last_i) word_o = TERM;
        else        word_o = DATA_W'(prev_w[RAM_AW-1:0]);
    end

endmodule

// File: rtl/blk_dma_engine.sv
module blk_dma_engine
    import blk_dma_pkg::*;
#(
    parameter int AW     = 32,
    parameter int RAM_AW = 21,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [CTL_W-1:0]  ctl_i,
    input  logic [AW-1:0]     base_i,
    input  logic [31:0]       blk_i,
    input  logic              otc_mode_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [CTL_W-1:0]  ctl_o,
    output logic              ram_req_o,
    output logic              ram_we_o,
    output logic [RAM_AW-1:0] ram_addr_o,
    output logic [DATA_W-1:0] ram_wdata_o,
    input  logic [DATA_W-1:0] ram_rdata_i,
    input  logic              ram_ready_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o,
    input  logic              out_ready_i,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] in_data_i,
    output logic              in_ready_o
);

    localparam logic [CTL_W-1:0] CLR_MASK =
        (CTL_W'(1) << EN_BIT) | (CTL_W'(1) << TRIG_BIT);

    typedef struct packed {
        logic              run;
        logic              done;
        logic              otc;
        logic [AW-1:0]     addr;
        logic [CNT_W-1:0]  remain;
        logic [CTL_W-1:0]  ctl;
    } state_t;

    state_t s_d, s_q;

    xfer_cfg_t        new_cfg_w;
    logic             new_legal_w;
    logic [CNT_W-1:0] new_count_w;
    logic [AW-1:0]    next_addr_w;
    logic [DATA_W-1:0] otc_word_w;
    logic             last_w;
    logic             from_w;
    logic             src_ok_w;
    logic             move_w;

    blk_dma_decode #(.CNT_W(CNT_W)) u_decode (
        .ctl_i   (ctl_i),
        .blk_i   (blk_i),
        .cfg_o   (new_cfg_w),
        .legal_o (new_legal_w),
        .count_o (new_count_w)
    );

    blk_dma_addr_step #(.AW(AW), .RAM_AW(RAM_AW), .DATA_W(DATA_W)) u_addr (
        .addr_i     (s_q.addr),
        .down_i     (s_q.ctl[STEP_BIT]),
        .next_o     (next_addr_w),
        .ram_addr_o (ram_addr_o)
    );

    blk_dma_otc_gen #(.AW(AW), .RAM_AW(RAM_AW), .DATA_W(DATA_W)) u_otc (
        .addr_i (s_q.addr),
        .last_i (last_w),
        .word_o (otc_word_w)
    );

    always_comb begin
        from_w   = s_q.ctl[DIR_BIT];
        last_w   = (s_q.remain == CNT_W'(1));
        if (from_w)      src_ok_w = out_ready_i;
        else if (s_q.otc) src_ok_w = 1'b1;
        else             src_ok_w = in_valid_i;

        ram_req_o   = s_q.run & src_ok_w;
        ram_we_o    = s_q.run & ~from_w;
        ram_wdata_o = s_q.otc ? otc_word_w : in_data_i;
        out_valid_o = s_q.run & from_w & ram_ready_i;
        out_data_o  = ram_rdata_i;
        in_ready_o  = s_q.run & ~from_w & ~s_q.otc & ram_ready_i;
        move_w      = ram_req_o & ram_ready_i;

        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.run) begin
            if (move_w) begin
                s_d.addr   = next_addr_w;
                s_d.remain = s_q.remain - CNT_W'(1);
                if (last_w) begin
                    s_d.run  = 1'b0;
                    s_d.done = 1'b1;
                    s_d.ctl  = s_q.ctl & ~CLR_MASK;
                end
            end
        end else if (start_i && ctl_i[EN_BIT] && new_legal_w) begin
            s_d.ctl    = ctl_i;
            s_d.addr   = base_i;
            s_d.otc    = otc_mode_i;
            s_d.remain = new_count_w;
            if (new_count_w == '0) begin
                s_d.done = 1'b1;
                s_d.ctl  = ctl_i & ~CLR_MASK;
            end else begin
                s_d.run = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign busy_o = s_q.run;
    assign done_o = s_q.done;
    assign ctl_o  = s_q.ctl;

    assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && !ctl_o[EN_BIT] && !ctl_o[TRIG_BIT]));

    assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !(ram_req_o && ram_ready_i)) |=> (busy_o && $stable(ram_addr_o)));

    assert_addr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && ram_req_o && ram_ready_i) |=>
            (!busy_o || ram_addr_o == (ctl_o[STEP_BIT] ? $past(ram_addr_o) - RAM_AW'(4)
                                                        : $past(ram_addr_o) + RAM_AW'(4))));

    assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (!ram_req_o && !out_valid_o && !in_ready_o));

    assert_read_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ram_req_o && !ram_we_o) |-> out_ready_i);

endmodule

// File: tb/blk_dma_engine_bench.sv
`timescale 1ns/1ps
module blk_dma_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ctl = '0, base = '0, blk = '0;
    logic        otc = 1'b0;
    logic        busy, done;
    logic [31:0] ctl_out;
    logic        ram_req, ram_we, ram_ready;
    logic [20:0] ram_addr;
    logic [31:0] ram_wdata, ram_rdata;
    logic        out_valid, out_ready, in_valid, in_ready;
    logic [31:0] out_data, in_data;
    logic        stall_en = 1'b0;

    int unsigned cyc = 0;
    int unsigned moves = 0;
    int unsigned cap_n = 0;
    int unsigned in_n = 0;
    logic [31:0] mem [0:1023];
    logic [31:0] cap [0:255];
    int checks = 0, fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign ram_rdata = mem[ram_addr[11:2]];
    assign ram_ready = !stall_en || cyc[0];
    assign out_ready = !stall_en || !cyc[1];
    assign in_valid  = !stall_en || (cyc % 3 != 0);
    assign in_data   = 32'h5000_0000 + in_n;

    blk_dma_engine u_blk_dma_engine (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ctl_i(ctl), .base_i(base),
        .blk_i(blk), .otc_mode_i(otc), .busy_o(busy), .done_o(done), .ctl_o(ctl_out),
        .ram_req_o(ram_req), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
        .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata), .ram_ready_i(ram_ready),
        .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready),
        .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ram_req && ram_ready) moves <= moves + 1;
        if (ram_req && ram_ready && ram_we) mem[ram_addr[11:2]] <= ram_wdata;
        if (out_valid && out_ready) begin
            cap[cap_n % 256] <= out_data;
            cap_n <= cap_n + 1;
        end
        if (in_valid && in_ready) in_n <= in_n + 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic preload();
        for (int i = 0; i < 1024; i++) mem[i] = 32'hA000_0000 + i;
    endtask

    task automatic run_xfer(input logic [31:0] c, input logic [31:0] b, input logic [31:0] k,
                            input bit o, output int unsigned nmoves, output bit got_done);
        int unsigned snap;
        int waited;
        @(negedge clk);
        snap = moves;
        ctl = c; base = b; blk = k; otc = o; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_done = 0;
        waited = 0;
        while (!done && waited < 70000) begin
            @(negedge clk);
            waited++;
        end
        if (done) begin
            got_done = 1;
            check(busy == 1'b0, "R10 busy low with done", 32'(busy), 0);
            check(ctl_out == (c & ~32'h1100_0000), "R10 control word cleared", ctl_out, c & ~32'h1100_0000);
            @(negedge clk);
            check(done == 1'b0, "R10 done one cycle", 32'(done), 0);
        end else begin
            check(1'b0, "watchdog transfer end", 0, 1);
        end
        nmoves = moves - snap;
    endtask

    typedef struct packed {
        logic [31:0] c;
        logic [31:0] b;
        logic [31:0] k;
        logic        o;
        logic [31:0] n;
    } vec_t;

    // R2/R3/R4 word counts: mode 0 -> size, mode 1 -> size*count
    localparam vec_t VECS [6] = '{
        '{32'h0100_0001, 32'h0000_0100, 32'h0000_0005, 1'b0, 32'd5},
        '{32'h0100_0003, 32'h0000_0100, 32'h0000_0003, 1'b0, 32'd3},
        '{32'h1100_0201, 32'h0000_0000, 32'h0003_0004, 1'b0, 32'd12},
        '{32'h0100_0201, 32'h0000_0000, 32'h0000_0004, 1'b0, 32'd0},
        '{32'h0100_0002, 32'h0000_0300, 32'h0000_0008, 1'b1, 32'd8},
        '{32'h0100_0200, 32'h0000_0200, 32'h0002_0002, 1'b0, 32'd4}
    };

    initial begin
        #(4 * 195000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned n, snap, isnap;
        bit got;
        logic [31:0] a, expv, prev_ctl;
        preload();
        repeat (3) @(negedge clk);
        // R11 reset state
        check(busy == 0, "R11 busy after reset", 32'(busy), 0);
        check(done == 0, "R11 done after reset", 32'(done), 0);
        check(ctl_out == 0, "R11 ctl after reset", ctl_out, 0);
        rst_n = 1'b1;

        foreach (VECS[i]) begin
            run_xfer(VECS[i].c, VECS[i].b, VECS[i].k, VECS[i].o, n, got);
            check(n == VECS[i].n, "R3 R4 word count", n, VECS[i].n);
        end

        // R1 ignored strobes: enable clear, then counting mode 2
        prev_ctl = ctl_out;
        for (int t = 0; t < 2; t++) begin
            @(negedge clk);
            snap = moves;
            ctl = (t == 0) ? 32'h0000_0001 : 32'h0100_0401;
            blk = 32'h0000_0004; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            got = 0;
            repeat (5) begin
                if (busy || done) got = 1;
                @(negedge clk);
            end
            check(!got, "R1 strobe ignored", 32'(got), 0);
            check(moves == snap, "R1 no access", moves - snap, 0);
            check(ctl_out == prev_ctl, "R1 ctl unchanged", ctl_out, prev_ctl);
        end

        // R6/R5 read upward: words at index 16..19
        preload();
        snap = cap_n;
        run_xfer(32'h0100_0001, 32'h0000_0040, 32'h0000_0004, 1'b0, n, got);
        for (int k = 0; k < 4; k++)
            check(cap[(snap + k) % 256] == 32'hA000_0010 + k, "R6 read up data",
                  cap[(snap + k) % 256], 32'hA000_0010 + k);

        // R2/R5 read downward: indices 16,15,14
        snap = cap_n;
        run_xfer(32'h0100_0003, 32'h0000_0040, 32'h0000_0003, 1'b0, n, got);
        for (int k = 0; k < 3; k++)
            check(cap[(snap + k) % 256] == 32'hA000_0010 - k, "R5 read down data",
                  cap[(snap + k) % 256], 32'hA000_0010 - k);

        // R5 upper address bits masked: 0xFFE00010 -> index 4
        snap = cap_n;
        run_xfer(32'h0100_0001, 32'hFFE0_0010, 32'h0000_0002, 1'b0, n, got);
        check(cap[snap % 256] == 32'hA000_0004, "R5 address mask", cap[snap % 256], 32'hA000_0004);

        // R7 chain generator, downward from 0x100, 8 words
        preload();
        run_xfer(32'h0100_0002, 32'h0000_0100, 32'h0000_0008, 1'b1, n, got);
        for (int k = 0; k < 8; k++) begin
            a = 32'h100 - 4 * k;
            expv = (k == 7) ? 32'h00FF_FFFF : ((a - 4) & 32'h001F_FFFF);
            check(mem[a[11:2]] == expv, "R7 chain word", mem[a[11:2]], expv);
        end

        // R8/R9 input stream under stalls
        stall_en = 1'b1;
        isnap = in_n;
        run_xfer(32'h0100_0000, 32'h0000_0200, 32'h0000_0006, 1'b0, n, got);
        check(n == 6, "R9 words under stall", n, 6);
        for (int k = 0; k < 6; k++)
            check(mem[(32'h200 >> 2) + k] == 32'h5000_0000 + isnap + k, "R8 stream write",
                  mem[(32'h200 >> 2) + k], 32'h5000_0000 + isnap + k);

        // R6/R9 output stream under stalls
        preload();
        snap = cap_n;
        run_xfer(32'h0100_0001, 32'h0000_0080, 32'h0000_0006, 1'b0, n, got);
        check(cap_n - snap == 6, "R9 delivered once", cap_n - snap, 6);
        for (int k = 0; k < 6; k++)
            check(cap[(snap + k) % 256] == 32'hA000_0020 + k, "R9 stalled read data",
                  cap[(snap + k) % 256], 32'hA000_0020 + k);
        stall_en = 1'b0;

        // R3 size zero in mode 0 means 65536 words
        run_xfer(32'h0100_0001, 32'h0000_0000, 32'h0000_0000, 1'b0, n, got);
        check(n == 65536, "R3 zero size full block", n, 65536);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule